// File: doc/BRIEF.md
# Page Write Load and Programming Sequencer

This block collects the byte-load strobes that a bus front end produces for a byte-alterable nonvolatile array and groups them into page programming cycles. A page is 128 bytes. The upper address bits name the page, and the low seven bits pick a byte within it. The first load opens a page and fixes its page address. Further loads to the same page are stored in a page buffer. A per-location valid bit records which offsets have been loaded.

A retriggerable load window, counted in microsecond ticks, decides when loading is over. Every accepted byte restarts the window, so a page stays open for as long as loads keep arriving in time. When a full window passes with no accepted load, the block goes busy and runs a self-timed programming phase. In that phase it walks the page offsets in ascending order and writes each loaded byte, and only those, to a synchronous RAM that stands in for the array. It stays busy until the walk is over and a programming timer has counted its full duration. A load to a different page while a page is open raises a page-violation flag. Loads that arrive while busy are dropped and counted.

Top module: `pgwr_seq`

## Requirements
- R1: After reset, busy, mem_we and page_viol are 0 and rej_cnt is 0.
- R2: When no page is open and the block is not busy, a load opens a page. The page number is ld_addr[15:7], the byte offset is ld_addr[6:0], and the byte is stored at that offset.
- R3: While a page is open, each accepted load restarts the window. A load in the same clock as the window-ending tick is accepted. Once WIN_US ticks arrive with no accepted load, busy goes to 1 on the clock after the last of those ticks. Loads spaced closer than the window keep the page open without limit.
- R4: While a page is open, a load whose ld_addr[15:7] differs from the open page sets page_viol to 1 on the next clock. That byte is never written to the RAM and does not restart the window. page_viol returns to 0 when the next page is opened.
- R5: Programming starts in the first busy cycle and visits offsets 0 to 127, one per clock. It asserts mem_we only for offsets that were loaded, with mem_addr = {page, offset}.
- R6: When one offset is loaded several times within a page, the RAM receives the most recent data only.
- R7: busy returns to 0 on the clock after both the offset walk is finished and PROG_US ticks have been counted since programming began. The valid bits are then clear, so the next page writes only its own bytes.
- R8: Loads that arrive while busy have no effect on the RAM or the page. Each one increments rej_cnt, which saturates at 2^REJ_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-clock pulse once per microsecond |
| ld_stb | input | 1 | Byte-load strobe from the bus front end |
| ld_addr | input | 16 | Address of the byte being loaded |
| ld_data | input | 8 | Data of the byte being loaded |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM write address |
| mem_wdata | output | 8 | RAM write data |
| busy | output | 1 | Programming phase in progress |
| page_viol | output | 1 | A load targeted a different page than the open one |
| rej_cnt | output | 8 | Saturating count of loads dropped while busy |

## Verification
The hardest cases to reach from the ports are a load that lands in exactly the clock of the window-ending tick, and a page-violation load placed between valid loads. The ticks come every third clock, and the stimulus steps the gap between loads through a range that straddles the window length. Some loads therefore meet the expiring tick, some arrive just after it, and the late ones end up rejected during the following programming phase. A behavioural model follows every one of these cases on each clock. A run of rejected loads longer than the counter range checks saturation, and a full 128-byte page checks the complete walk.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_PROG = 2'd2
  } pg_phase_e;
endpackage

// File: rtl/pgwr_window.sv
module pgwr_window #(
  parameter int WIN_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic expire
);
  localparam int WC_W = $clog2(WIN_US + 1);

  logic [WC_W-1:0] cnt_q, cnt_d;

  assign expire = run & ~restart & tick & (cnt_q == WC_W'(WIN_US - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (run && tick)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  // R3
  win_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  // R3
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
  parameter int OFF_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);
  localparam int SLOTS = 1 << OFF_W;

  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (clr)
      vld_d = '0;
    else if (wr_en)
      vld_d[wr_off] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      vld_q <= '0;
    else
      vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      slot_q[wr_off] <= wr_data;
  end

  assign rd_data = slot_q[rd_off];
  assign rd_vld  = vld_q[rd_off];

  // R7
  clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !wr_en);

  // R6
  wr_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> vld_q[$past(wr_off)]);
endmodule

// File: rtl/pgwr_prog.sv
module pgwr_prog #(
  parameter int OFF_W   = 7,
  parameter int PROG_US = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             tick,
  output logic [OFF_W-1:0] ptr,
  output logic             scan_done,
  output logic             finish
);
  localparam int PT_W = $clog2(PROG_US + 1);
  localparam logic [OFF_W-1:0] LAST = {OFF_W{1'b1}};

  logic [OFF_W-1:0] ptr_q, ptr_d;
  logic             sd_q, sd_d;
  logic [PT_W-1:0]  pcnt_q, pcnt_d;
  logic             time_up;

  assign time_up   = (pcnt_q == PT_W'(PROG_US));
  assign finish    = active & sd_q & time_up;
  assign ptr       = ptr_q;
  assign scan_done = sd_q;

  always_comb begin
    ptr_d  = ptr_q;
    sd_d   = sd_q;
    pcnt_d = pcnt_q;
    if (start || finish) begin
      ptr_d  = '0;
      sd_d   = 1'b0;
      pcnt_d = '0;
    end else if (active) begin
      if (!sd_q) begin
        if (ptr_q == LAST)
          sd_d = 1'b1;
        else
          ptr_d = ptr_q + 1'b1;
      end
      if (tick && !time_up)
        pcnt_d = pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      sd_q   <= 1'b0;
      pcnt_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      sd_q   <= sd_d;
      pcnt_q <= pcnt_d;
    end
  end

  // R5
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sd_q && !finish && (ptr_q != LAST)) |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R7
  scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sd_q && (ptr_q == LAST)) |=> sd_q);
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int OFF_W   = 7,
  parameter int WIN_US  = 100,
  parameter int PROG_US = 5000,
  parameter int REJ_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              ld_stb,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              page_viol,
  output logic [REJ_W-1:0]  rej_cnt
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  pg_phase_e         phase_q, phase_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              viol_q, viol_d;
  logic [REJ_W-1:0]  rej_q, rej_d;

  logic [PAGE_W-1:0] ld_page;
  logic [OFF_W-1:0]  ld_off;
  logic              take, first, same_pg, accept, mism;
  logic              expire, finish, sdone, slot_vld;
  logic [OFF_W-1:0]  ptr;
  logic [DATA_W-1:0] slot_data;

  assign ld_page = ld_addr[ADDR_W-1:OFF_W];
  assign ld_off  = ld_addr[OFF_W-1:0];
  assign busy    = (phase_q == PH_PROG);
  assign take    = ld_stb & ~busy;
  assign first   = take & (phase_q == PH_IDLE);
  assign same_pg = (ld_page == page_q);
  assign accept  = first | (take & (phase_q == PH_LOAD) & same_pg);
  assign mism    = take & (phase_q == PH_LOAD) & ~same_pg;

  pgwr_window #(.WIN_US(WIN_US)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (phase_q == PH_LOAD),
    .restart (accept),
    .tick    (us_tick),
    .expire  (expire)
  );

  pgwr_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_off  (ld_off),
    .wr_data (ld_data),
    .clr     (finish),
    .rd_off  (ptr),
    .rd_data (slot_data),
    .rd_vld  (slot_vld)
  );

  pgwr_prog #(.OFF_W(OFF_W), .PROG_US(PROG_US)) u_prog (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (expire),
    .active    (busy),
    .tick      (us_tick),
    .ptr       (ptr),
    .scan_done (sdone),
    .finish    (finish)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (first)  phase_d = PH_LOAD;
      PH_LOAD: if (expire) phase_d = PH_PROG;
      PH_PROG: if (finish) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    page_d = first ? ld_page : page_q;
    viol_d = viol_q;
    if (first)
      viol_d = 1'b0;
    else if (mism)
      viol_d = 1'b1;
    rej_d = rej_q;
    if (ld_stb && busy && !(&rej_q))
      rej_d = rej_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      page_q  <= '0;
      viol_q  <= 1'b0;
      rej_q   <= '0;
    end else begin
      phase_q <= phase_d;
      page_q  <= page_d;
      viol_q  <= viol_d;
      rej_q   <= rej_d;
    end
  end

  assign mem_we    = busy & ~sdone & slot_vld;
  assign mem_addr  = {page_q, ptr};
  assign mem_wdata = slot_data;
  assign page_viol = viol_q;
  assign rej_cnt   = rej_q;

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(phase_q) == PH_LOAD));

  // R5
  we_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R4
  viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mism |=> (page_viol && (page_q == $past(page_q))));

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(sdone));

  // R8
  rej_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ld_stb && !(&rej_cnt)) |=> (rej_cnt == $past(rej_cnt) + 1'b1));
endmodule

// File: tb/pgwr_seq_tb.sv
module pgwr_seq_tb;
  localparam int CLK_P   = 10;
  localparam int WIN_US  = 4;
  localparam int PROG_US = 50;
  localparam int REJ_W   = 3;
  localparam int REJ_MAX = 7;

  logic        clk;
  logic        rst_n;
  logic        us_tick;
  logic        ld_stb;
  logic [15:0] ld_addr;
  logic [7:0]  ld_data;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        busy;
  logic        page_viol;
  logic [REJ_W-1:0] rej_cnt;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit fin = 0;

  pgwr_seq #(.WIN_US(WIN_US), .PROG_US(PROG_US), .REJ_W(REJ_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ld_stb(ld_stb),
    .ld_addr(ld_addr), .ld_data(ld_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .page_viol(page_viol), .rej_cnt(rej_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // tick every third clock
  int tk = 0;
  always @(negedge clk) begin
    tk = (tk == 2) ? 0 : tk + 1;
    us_tick <= (tk == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int  m_buf[128];
  bit  m_vld[128];
  int  m_page, m_win, m_ptr, m_pt, m_rej;
  bit  m_open, m_busy, m_sd, m_viol, m_acc;
  int  ram_dut[int];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_open = 0; m_busy = 0; m_sd = 0; m_viol = 0;
      m_page = 0; m_win = 0; m_ptr = 0; m_pt = 0; m_rej = 0;
      for (int i = 0; i < 128; i++) m_vld[i] = 0;
    end else if (m_busy) begin
      if (ld_stb && m_rej < REJ_MAX) m_rej++;
      if (m_sd && m_pt == PROG_US) begin
        m_busy = 0; m_sd = 0; m_ptr = 0; m_pt = 0;
        for (int i = 0; i < 128; i++) m_vld[i] = 0;
      end else begin
        if (!m_sd) begin
          if (m_ptr == 127) m_sd = 1; else m_ptr++;
        end
        if (us_tick && m_pt < PROG_US) m_pt++;
      end
    end else if (!m_open) begin
      if (ld_stb) begin
        m_open = 1; m_page = int'(ld_addr) >> 7;
        m_buf[ld_addr[6:0]] = ld_data; m_vld[ld_addr[6:0]] = 1;
        m_win = 0; m_viol = 0;
      end
    end else begin
      m_acc = 0;
      if (ld_stb) begin
        if ((int'(ld_addr) >> 7) == m_page) begin
          m_buf[ld_addr[6:0]] = ld_data; m_vld[ld_addr[6:0]] = 1;
          m_acc = 1; m_win = 0;
        end else m_viol = 1;
      end
      if (!m_acc && us_tick) begin
        if (m_win == WIN_US - 1) begin
          m_open = 0; m_busy = 1; m_ptr = 0; m_pt = 0; m_sd = 0;
        end else m_win++;
      end
    end
  end

  always @(posedge clk)
    if (rst_n && mem_we) ram_dut[int'(mem_addr)] = int'(mem_wdata);

  // per-clock comparison against the model
  bit exp_we;
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      exp_we = m_busy && !m_sd && m_vld[m_ptr];
      check(busy == m_busy, "R3/R7 busy", busy, m_busy);
      check(mem_we == exp_we, "R5 mem_we", mem_we, exp_we);
      if (exp_we) begin
        check(int'(mem_addr) == m_page * 128 + m_ptr, "R5 mem_addr", mem_addr, m_page * 128 + m_ptr);
        check(int'(mem_wdata) == m_buf[m_ptr], "R6 mem_wdata", mem_wdata, m_buf[m_ptr]);
      end
      check(page_viol == m_viol, "R4 page_viol", page_viol, m_viol);
      check(int'(rej_cnt) == m_rej, "R8 rej_cnt", rej_cnt, m_rej);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      fin = 1;
      failures++;
      $display("FAIL R7 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic load(input int a, input int d);
    @(negedge clk);
    ld_stb = 1'b1; ld_addr = 16'(a); ld_data = 8'(d);
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    idle(20);
    while (busy) @(negedge clk);
    idle(2);
  endtask

  function automatic int ram_at(input int a);
    return ram_dut.exists(a) ? ram_dut[a] : -1;
  endfunction

  initial begin
    rst_n = 1'b0; ld_stb = 1'b0; ld_addr = '0; ld_data = '0;
    idle(3);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(mem_we == 0, "R1 mem_we", mem_we, 0);
    check(page_viol == 0, "R1 page_viol", page_viol, 0);
    check(rej_cnt == 0, "R1 rej_cnt", rej_cnt, 0);
    rst_n = 1'b1;

    // page 0x12: sparse offsets, offset 5 loaded twice (R2, R6)
    load(16'h0905, 8'hA1); idle(2);
    load(16'h0900, 8'h10); idle(5);
    load(16'h097F, 8'h7F); idle(3);
    load(16'h0905, 8'hB2);
    while (!busy) @(negedge clk);
    // R8: loads during busy, more than counter range
    for (int i = 0; i < 9; i++) load(16'h2000 + i, i);
    while (busy) @(negedge clk);
    idle(2);
    check(rej_cnt == 3'(REJ_MAX), "R8 saturated", rej_cnt, REJ_MAX);
    check(ram_at(16'h0905) == 8'hB2, "R6 last data", ram_at(16'h0905), 8'hB2);
    check(ram_at(16'h0900) == 8'h10, "R2 offset 0", ram_at(16'h0900), 8'h10);
    check(ram_at(16'h097F) == 8'h7F, "R2 offset 127", ram_at(16'h097F), 8'h7F);
    check(ram_at(16'h0901) == -1, "R5 unloaded slot", ram_at(16'h0901), -1);
    check(ram_at(16'h2000) == -1, "R8 ignored load", ram_at(16'h2000), -1);

    // page 0x68 with a foreign-page load (R4) and gaps around the window (R3)
    load(16'h3401, 8'h11);
    load(16'h3402, 8'h22);
    load(16'h5602, 8'h99);
    idle(1);
    check(page_viol == 1, "R4 flag set", page_viol, 1);
    for (int k = 0; k < 20; k++) begin
      load(16'h3410 + k, 8'h40 + k);
      idle(7 + (k % 7));
    end
    drain();
    check(ram_at(16'h5602) == -1, "R4 byte dropped", ram_at(16'h5602), -1);
    check(ram_at(16'h3401) == 8'h11, "R2 page 0x68", ram_at(16'h3401), 8'h11);

    // long page: loads inside the window keep it open (R3), flag clears (R4)
    load(16'h4000, 8'h01);
    idle(1);
    check(page_viol == 0, "R4 flag cleared", page_viol, 0);
    for (int k = 1; k < 30; k++) begin
      idle(7);
      check(busy == 0, "R3 window held open", busy, 0);
      load(16'h4000 + k, k + 1);
    end
    drain();
    check(ram_at(16'h401D) == 30, "R3 last of long page", ram_at(16'h401D), 30);
    check(ram_at(16'h0905) == 8'hB2, "R7 earlier page intact", ram_at(16'h0905), 8'hB2);

    // full page, back to back (R5, R7)
    for (int i = 0; i < 128; i++) load(16'hFF80 + i, i ^ 8'h5A);
    drain();
    check(ram_at(16'hFF80) == 8'h5A, "R5 full page first", ram_at(16'hFF80), 8'h5A);
    check(ram_at(16'hFFFF) == (127 ^ 8'h5A), "R5 full page last", ram_at(16'hFFFF), 127 ^ 8'h5A);
    check(busy == 0, "R7 idle after full page", busy, 0);

    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule